// File: doc/BRIEF.md
# Self-Training Two-Input Bipolar Perceptron

This block is one hardware neuron that teaches itself a chosen two-input logic function: AND, NAND, OR or NOR. After a start pulse it clears its two weights and its bias. It then works through a fixed set of four bipolar input pairs, one pair per clock cycle. For each pair it forms the weighted sum with the bias, compares that sum with a programmable threshold, and produces a response of +1, -1 or 0. It subtracts the response from the target the selected function demands, and moves its weights and bias toward the target whenever the two differ. All values are signed fixed-point integers, and weight updates saturate instead of wrapping.

A full pass over the four pairs is one epoch. Training ends as soon as an epoch has no error on any pair; the converged flag is then raised and the weights are frozen. Training also ends if a configurable epoch limit is reached first, and in that case the converged flag stays low.

Each step is reported on plain status outputs with a one-cycle `step_valid` strobe: the pair index, the target, the response, the error and the updated weights. The block neither sinks nor sources a data stream, so no valid/ready handshake is used and no back-pressure exists. A caller that wants every step must sample on each cycle that `step_valid` is high. The function, learning rate and threshold are captured only at start.

Top module: `perceptron_trainer`

## Requirements
- R1: After reset, weights, bias, epoch count, converged and busy are all zero. The cycle after a start pulse is sampled, weights, bias, epoch and converged are zero and busy is high, whatever state came before.
- R2: While busy, one step runs per clock, with `step_valid` high. Pair index 0,1,2,3 repeats in order, and the inputs (x1,x2) are (+1,+1), (+1,-1), (-1,+1), (-1,-1) for indices 0 to 3.
- R3: `func_sel` 0=AND, 1=NAND, 2=OR, 3=NOR. The targets for indices 0..3 are AND +1,-1,-1,-1; NAND -1,+1,+1,+1; OR +1,+1,+1,-1; NOR -1,-1,-1,+1. Bipolar values are 2-bit two's complement: 01=+1, 11=-1, 00=0.
- R4: The response is +1 when w1·x1 + w2·x2 + bias is greater than the threshold, -1 when it is smaller, and 0 when it is equal. The sum is computed from the weights held before the step.
- R5: The error is target minus response, as a 3-bit signed value from -2 to +2. When the error is non-zero, each weight changes by learn_rate × sign(error) × its input and the bias by learn_rate × sign(error). When the error is zero, nothing changes.
- R6: Weights and bias are WGT_W-bit signed and clamp at -2^(WGT_W-1) and 2^(WGT_W-1)-1 instead of wrapping.
- R7: The epoch count increments on the step with index 3. If every step of that epoch had zero error, converged rises and busy falls on the same edge. After that the weights stay unchanged until the next start.
- R8: If the epoch count reaches MAX_EPOCH without convergence, busy falls with converged low. The count never exceeds MAX_EPOCH.
- R9: With threshold 0 and learning rate L, every function converges with an epoch count of 2. The final (w1,w2,bias) is L×(1,1,-1) for AND, L×(-1,-1,1) for NAND, L×(1,1,1) for OR and L×(-1,-1,-1) for NOR.
- R10: Changing `func_sel`, `learn_rate` or `threshold` while busy has no effect on the run in progress.
- R11: A start pulse while busy abandons the run and begins a fresh one with the newly sampled settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle pulse: clear state and begin training |
| func_sel | input | 2 | Function to learn, sampled at start |
| learn_rate | input | LR_W | Unsigned learning rate, sampled at start |
| threshold | input | TH_W | Signed threshold, sampled at start |
| busy | output | 1 | Training in progress |
| step_valid | output | 1 | Step outputs below are fresh this cycle |
| pat_idx | output | 2 | Index of the pair just processed |
| target | output | 2 | Target for that pair, bipolar code |
| actual | output | 2 | Response for that pair, bipolar code |
| error | output | 3 | Target minus response, signed |
| weight1 | output | WGT_W | Weight of x1 after the step, signed |
| weight2 | output | WGT_W | Weight of x2 after the step, signed |
| bias | output | WGT_W | Bias after the step, signed |
| epoch | output | EPW | Completed epochs |
| converged | output | 1 | Last run ended with an error-free epoch |

## Verification
The start pulse takes effect on the edge that samples it, so the cleared state is checked in the low phase right after that edge. Step n of a run is registered on the n-th following edge, together with its index, target, response, error and updated weights. The bench therefore compares each step one falling edge after that step's rising edge, against a step model of its own. The epoch count, converged and busy change on the edge of the final step of an epoch, and are checked in the same half cycle and once more in the idle cycle after.

// File: rtl/pcpt_pkg.sv
package pcpt_pkg;
  typedef logic signed [1:0] bip_t;
  localparam bip_t BIP_POS  = 2'sb01;
  localparam bip_t BIP_NEG  = 2'sb11;
  localparam bip_t BIP_ZERO = 2'sb00;
  // bit0 inverts the result, bit1 selects the OR family
  typedef enum logic [1:0] {FN_AND = 2'd0, FN_NAND = 2'd1, FN_OR = 2'd2, FN_NOR = 2'd3} fn_e;
endpackage

// File: rtl/pcpt_pattern_gen.sv
module pcpt_pattern_gen
  import pcpt_pkg::*;
(
  input  logic [1:0] idx,
  input  logic [1:0] fn,
  output bip_t       x1,
  output bip_t       x2,
  output bip_t       tgt
);
  logic hit;
  always_comb begin
    x1  = idx[1] ? BIP_NEG : BIP_POS;
    x2  = idx[0] ? BIP_NEG : BIP_POS;
    hit = fn[1] ? (idx != 2'd3) : (idx == 2'd0);
    tgt = (hit ^ fn[0]) ? BIP_POS : BIP_NEG;
  end
endmodule

// File: rtl/pcpt_neuron.sv
module pcpt_neuron
  import pcpt_pkg::*;
#(
  parameter int WGT_W = 16,
  parameter int TH_W  = 16
) (
  input  logic signed [WGT_W-1:0] w1,
  input  logic signed [WGT_W-1:0] w2,
  input  logic signed [WGT_W-1:0] bias,
  input  logic signed [TH_W-1:0]  thr,
  input  bip_t                    x1,
  input  bip_t                    x2,
  input  bip_t                    tgt,
  output bip_t                    y,
  output logic signed [2:0]       err
);
  localparam int SW = ((WGT_W > TH_W) ? WGT_W : TH_W) + 3;
  logic signed [SW-1:0] t1, t2, acc;

  always_comb begin
    t1  = (x1 == BIP_NEG) ? -SW'(w1) : SW'(w1);
    t2  = (x2 == BIP_NEG) ? -SW'(w2) : SW'(w2);
    acc = t1 + t2 + SW'(bias) - SW'(thr);
    if (acc > 0)      y = BIP_POS;
    else if (acc < 0) y = BIP_NEG;
    else              y = BIP_ZERO;
    err = {tgt[1], tgt} - {y[1], y};
  end
endmodule

// File: rtl/pcpt_update.sv
module pcpt_update
  import pcpt_pkg::*;
#(
  parameter int WGT_W = 16,
  parameter int LR_W  = 8
) (
  input  logic signed [WGT_W-1:0] w_cur,
  input  bip_t                    x,
  input  logic signed [2:0]       err,
  input  logic [LR_W-1:0]         lr,
  output logic signed [WGT_W-1:0] w_nxt
);
  localparam int EW = ((WGT_W > LR_W) ? WGT_W : LR_W) + 2;
  localparam logic signed [EW-1:0] HI = {{(EW-WGT_W+1){1'b0}}, {(WGT_W-1){1'b1}}};
  localparam logic signed [EW-1:0] LO = {{(EW-WGT_W+1){1'b1}}, {(WGT_W-1){1'b0}}};

  logic signed [EW-1:0] mag, sum;
  logic                 down;

  always_comb begin
    mag  = $signed({{(EW-LR_W){1'b0}}, lr});
    down = err[2] ^ (x == BIP_NEG);
    if (err == 3'sd0) sum = EW'(w_cur);
    else if (down)    sum = EW'(w_cur) - mag;
    else              sum = EW'(w_cur) + mag;
    if (sum > HI)      w_nxt = HI[WGT_W-1:0];
    else if (sum < LO) w_nxt = LO[WGT_W-1:0];
    else               w_nxt = sum[WGT_W-1:0];
  end
endmodule

// File: rtl/perceptron_trainer.sv
module perceptron_trainer
  import pcpt_pkg::*;
#(
  parameter int WGT_W     = 16,
  parameter int TH_W      = 16,
  parameter int LR_W      = 8,
  parameter int MAX_EPOCH = 64,
  localparam int EPW      = $clog2(MAX_EPOCH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [1:0]              func_sel,
  input  logic [LR_W-1:0]         learn_rate,
  input  logic signed [TH_W-1:0]  threshold,
  output logic                    busy,
  output logic                    step_valid,
  output logic [1:0]              pat_idx,
  output logic [1:0]              target,
  output logic [1:0]              actual,
  output logic [2:0]              error,
  output logic signed [WGT_W-1:0] weight1,
  output logic signed [WGT_W-1:0] weight2,
  output logic signed [WGT_W-1:0] bias,
  output logic [EPW-1:0]          epoch,
  output logic                    converged
);
  localparam int NW = 3;  // 0: bias, 1: x1 weight, 2: x2 weight

  logic [1:0]              run_fn;
  logic [LR_W-1:0]         run_lr;
  logic signed [TH_W-1:0]  run_thr;
  logic [1:0]              idx;
  logic                    dirty;
  logic signed [WGT_W-1:0] wq [NW];
  logic signed [WGT_W-1:0] wn [NW];
  bip_t                    xs [NW];
  bip_t                    x1, x2, tgt, y;
  logic signed [2:0]       err;

  pcpt_pattern_gen u_pat (.idx(idx), .fn(run_fn), .x1(x1), .x2(x2), .tgt(tgt));

  pcpt_neuron #(.WGT_W(WGT_W), .TH_W(TH_W)) u_neur (
    .w1(wq[1]), .w2(wq[2]), .bias(wq[0]), .thr(run_thr),
    .x1(x1), .x2(x2), .tgt(tgt), .y(y), .err(err)
  );

  assign xs[0] = BIP_POS;
  assign xs[1] = x1;
  assign xs[2] = x2;

  for (genvar g = 0; g < NW; g++) begin : g_upd
    pcpt_update #(.WGT_W(WGT_W), .LR_W(LR_W)) u_upd (
      .w_cur(wq[g]), .x(xs[g]), .err(err), .lr(run_lr), .w_nxt(wn[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_fn <= '0; run_lr <= '0; run_thr <= '0;
      idx <= '0; dirty <= 1'b0; busy <= 1'b0; step_valid <= 1'b0;
      pat_idx <= '0; target <= '0; actual <= '0; error <= '0;
      epoch <= '0; converged <= 1'b0;
      for (int i = 0; i < NW; i++) wq[i] <= '0;
    end else if (start) begin
      run_fn <= func_sel; run_lr <= learn_rate; run_thr <= threshold;
      idx <= '0; dirty <= 1'b0; busy <= 1'b1; step_valid <= 1'b0;
      pat_idx <= '0; target <= '0; actual <= '0; error <= '0;
      epoch <= '0; converged <= 1'b0;
      for (int i = 0; i < NW; i++) wq[i] <= '0;
    end else if (busy) begin
      step_valid <= 1'b1;
      pat_idx    <= idx;
      target     <= tgt;
      actual     <= y;
      error      <= err;
      for (int i = 0; i < NW; i++) wq[i] <= wn[i];
      idx <= idx + 2'd1;
      if (idx == 2'd3) begin
        epoch <= epoch + 1'b1;
        dirty <= 1'b0;
        if (!dirty && err == 3'sd0) begin
          converged <= 1'b1;
          busy      <= 1'b0;
        end else if (epoch == EPW'(MAX_EPOCH - 1)) begin
          busy <= 1'b0;
        end
      end else begin
        dirty <= dirty | (err != 3'sd0);
      end
    end else begin
      step_valid <= 1'b0;
    end
  end

  assign weight1 = wq[1];
  assign weight2 = wq[2];
  assign bias    = wq[0];

  AST_START_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (epoch == '0 && !converged && busy && bias == '0 && weight1 == '0)); // R1
  AST_STEP_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (step_valid && $past(step_valid)) |-> (pat_idx == $past(pat_idx) + 2'd1)); // R2
  AST_QUIET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !start && err == 3'sd0) |=> ($stable(weight1) && $stable(weight2) && $stable(bias))); // R5
  AST_CONV_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    converged |-> !busy); // R7
  AST_CONV_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (converged && !start) |=> converged); // R7
  AST_FROZEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> ($stable(weight1) && $stable(weight2) && $stable(bias))); // R7
  AST_EPOCH_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    epoch <= EPW'(MAX_EPOCH)); // R8
endmodule

// File: tb/tb_perceptron_trainer.sv
module tb_perceptron_trainer;
  localparam int CLK_PERIOD = 10;
  localparam int WGT_W = 10;
  localparam int TH_W  = 16;
  localparam int LR_W  = 8;
  localparam int MAXE  = 64;
  localparam int EPW   = $clog2(MAXE + 1);
  localparam int WHI   = (1 << (WGT_W - 1)) - 1;
  localparam int WLO   = -(1 << (WGT_W - 1));

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [1:0] func_sel = '0;
  logic [LR_W-1:0] learn_rate = '0;
  logic signed [TH_W-1:0] threshold = '0;
  logic busy, step_valid, converged;
  logic [1:0] pat_idx, target, actual;
  logic [2:0] error;
  logic signed [WGT_W-1:0] weight1, weight2, bias;
  logic [EPW-1:0] epoch;

  int n_chk = 0, n_bad = 0;
  int m_conv, m_ep, m_w1, m_w2, m_b;

  always #(CLK_PERIOD/2) clk = ~clk;

  perceptron_trainer #(.WGT_W(WGT_W), .TH_W(TH_W), .LR_W(LR_W), .MAX_EPOCH(MAXE)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .func_sel(func_sel), .learn_rate(learn_rate),
    .threshold(threshold), .busy(busy), .step_valid(step_valid), .pat_idx(pat_idx),
    .target(target), .actual(actual), .error(error), .weight1(weight1), .weight2(weight2),
    .bias(bias), .epoch(epoch), .converged(converged)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int sat(input int v);
    return (v > WHI) ? WHI : ((v < WLO) ? WLO : v);
  endfunction

  function automatic int tgt_of(input int fn, input int i);
    bit hit = (fn >= 2) ? (i != 3) : (i == 0);
    return ((hit ? 1 : 0) ^ (fn % 2)) ? 1 : -1;
  endfunction

  function automatic int s2(input logic [1:0] v);
    return int'($signed(v));
  endfunction

  // Runs a full training pass and checks every step against a step model.
  task automatic run_case(input int fn, input int lr, input int thr, input bit disturb);
    int w1 = 0, w2 = 0, b = 0, ep = 0, step = 0, dirty = 0, conv = 0;
    bit done = 0;
    @(negedge clk);
    func_sel = 2'(fn); learn_rate = LR_W'(lr); threshold = TH_W'(thr); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check("R1", "busy after start", int'(busy), 1);
    check("R1", "epoch after start", int'(epoch), 0);
    check("R1", "converged after start", int'(converged), 0);
    check("R1", "weights after start", int'(weight1) | int'(weight2) | int'(bias), 0);
    if (disturb) begin
      func_sel = 2'(fn + 1); learn_rate = LR_W'(lr + 7); threshold = TH_W'(thr + 300);
    end
    while (!done) begin
      int i = step % 4;
      int x1 = (i >= 2) ? -1 : 1;
      int x2 = (i % 2) ? -1 : 1;
      int t = tgt_of(fn, i);
      int s = w1 * x1 + w2 * x2 + b - thr;
      int y = (s > 0) ? 1 : ((s < 0) ? -1 : 0);
      int e = t - y;
      if (e != 0) begin
        w1 = sat(w1 + lr * t * x1);
        w2 = sat(w2 + lr * t * x2);
        b  = sat(b + lr * t);
      end
      if (i == 3) begin
        ep++;
        if (dirty == 0 && e == 0) begin conv = 1; done = 1; end
        else if (ep == MAXE) done = 1;
        dirty = 0;
      end else if (e != 0) dirty = 1;
      @(negedge clk);
      check("R2", "step_valid", int'(step_valid), 1);
      check("R2", "pat_idx", int'(pat_idx), i);
      check("R3", "target", s2(target), t);
      check("R4", "actual", s2(actual), y);
      check("R5", "error", int'($signed(error)), e);
      check("R5", "weight1", int'(weight1), w1);
      check("R5", "weight2", int'(weight2), w2);
      check("R5", "bias", int'(bias), b);
      check("R7", "epoch", int'(epoch), ep);
      step++;
    end
    check("R7", "busy at end", int'(busy), 0);
    check("R7", "converged at end", int'(converged), conv);
    @(negedge clk);
    check("R7", "step_valid idle", int'(step_valid), 0);
    check("R7", "frozen weight1", int'(weight1), w1);
    m_conv = conv; m_ep = ep; m_w1 = w1; m_w2 = w2; m_b = b;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    int ew1[4] = '{1, -1, 1, -1};
    int ew2[4] = '{1, -1, 1, -1};
    int eb[4]  = '{-1, 1, 1, -1};
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R1", "reset busy", int'(busy), 0);
    check("R1", "reset epoch", int'(epoch), 0);
    check("R1", "reset weights", int'(weight1) | int'(weight2) | int'(bias), 0);
    check("R1", "reset converged", int'(converged), 0);
    rst_n = 1'b1;

    // R9: unit rate and zero threshold, then a scaled rate
    for (int lr = 1; lr <= 5; lr += 4)
      for (int fn = 0; fn < 4; fn++) begin
        run_case(fn, lr, 0, 1'b0);
        check("R9", "converged", m_conv, 1);
        check("R9", "epochs", m_ep, 2);
        check("R9", "w1", m_w1, lr * ew1[fn]);
        check("R9", "w2", m_w2, lr * ew2[fn]);
        check("R9", "bias", m_b, lr * eb[fn]);
      end

    // R10: settings changed mid-run are ignored
    run_case(0, 1, 0, 1'b1);
    check("R10", "epochs with disturbance", m_ep, 2);
    check("R10", "bias with disturbance", m_b, -1);

    // R6 and R8: unreachable threshold saturates bias and hits the limit
    run_case(2, 200, 2000, 1'b0);
    check("R6", "bias saturated", int'(bias), WHI);
    check("R8", "epoch at limit", int'(epoch), MAXE);
    check("R8", "not converged", int'(converged), 0);

    // R11: restart in the middle of a run
    @(negedge clk);
    func_sel = 2'd3; learn_rate = 8'd3; threshold = 16'sd2000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (9) @(negedge clk);
    check("R11", "busy before restart", int'(busy), 1);
    run_case(1, 2, 0, 1'b0);
    check("R11", "restart converged", m_conv, 1);
    check("R11", "restart bias", m_b, 2);

    // random mix
    for (int k = 0; k < 30; k++)
      run_case(int'($urandom % 4), 1 + int'($urandom % 255),
               int'($urandom % 3001) - 1500, k[0]);

    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule